// File: doc/BRIEF.md
# LED Current Gradation Ramp Controller

This block keeps the setting of an LED current sink. Software writes a control byte and a target current code through a small register write port. The block does not jump to a new target. It walks its present current code one step at a time toward the target. The time between steps is taken from a table of eight step intervals, selected by a 3-bit field of the control byte. Intervals are counted in base ticks that come from an external clock prescaler. Entry 0 is one tick. Entry 1 is `STEP_UNIT` ticks, and each higher entry doubles the entry below it, so the fastest entry does not follow the doubling pattern.

The control byte also carries a full-scale doubling flag, a slow switch-edge flag and a two-bit operating mode. The mode is decoded into channel drive, boost-operation and boost-power outputs. In boost-regulator mode the current code has no effect. The output code is forced to zero and the ramp is parked at its present value, then it resumes from that value once another mode is selected. A four-state machine tracks the ramp. HOLD means the code equals the target. RISE and FALL mean the code is stepping up or down. PARK means boost mode. The state is taken from the register values that the next clock edge will load, so it always agrees with them.

Top module: `led_ramp_ctrl`

## Requirements
- R1: After reset the control readback is 0x0F (step field 111, doubling 1, slow edge 0, mode 00), the target is 0x00, `led_code` is 0x00, `led_en` is 0 and `ramp_done` is 1.
- R2: Control byte fields: bits 2:0 step field, bit 3 drives `fs_double`, bit 4 drives `slow_edge`, bits 6:5 mode. A write to bit 7 is ignored, and `ctrl_rdata[7]` always reads 0.
- R3: Mode decode: 00 sets `drive_ch1`=`drive_ch2`=`boost_power`=1. 01 sets `drive_ch1`=`boost_power`=1 and `drive_ch2`=0. 10 sets `boost_mode`=`boost_power`=1 with both channels 0. 11 sets both channels 1 with `boost_power`=0. `boost_mode` is 1 only for 10.
- R4: The step interval is 1 base tick for step code 000 and `STEP_UNIT`<<(code-1) base ticks for codes 001 to 111.
- R5: At each interval expiry the code moves by exactly one toward the target (up if below, down if above). It never passes the target.
- R6: The interval count restarts from zero on any write to the target or to the control byte. The first step after such a write comes one full interval later.
- R7: In mode 10, `led_code` reads 0 and the ramp is frozen. Leaving mode 10 restores the held code, and ramping continues from it.
- R8: `led_en` is 1 exactly when the output code is nonzero and the mode is not 10.
- R9: `ramp_done` is 1 exactly when the present code equals the target.
- R10: A write strobe sampled at a clock edge updates its register at that edge. Only clock edges with `base_tick` high advance the interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wr_target | input | 1 | Write strobe for the target code |
| wr_data | input | CODE_W | Write data (control uses bits 6:0) |
| base_tick | input | 1 | Base timing tick from prescaler |
| ctrl_rdata | output | 8 | Control byte readback, bit 7 zero |
| led_code | output | CODE_W | Present current code (0 in boost mode) |
| fs_double | output | 1 | Full-scale doubling flag |
| slow_edge | output | 1 | Slow switch-edge flag |
| drive_ch1 | output | 1 | Channel 1 regulated |
| drive_ch2 | output | 1 | Channel 2 regulated |
| boost_mode | output | 1 | High-voltage boost regulator mode |
| boost_power | output | 1 | Boost stage powered |
| led_en | output | 1 | Driver enabled |
| ramp_done | output | 1 | Present code equals target |

## Verification
The bench builds the block with `STEP_UNIT` = 4 instead of 16. This shrinks the longest interval to 256 ticks, so full 255-code ramps at several step codes, and a single step at code 111, fit within the run. With `base_tick` held high, each interval becomes an exact cycle count. The bench can then sample on the last cycle before each expected step and on the cycle of the step, in both directions. The bench also gates `base_tick`, freezes the ramp in boost mode partway through a ramp, and rewrites the target midway through an interval.

// File: rtl/led_ramp_pkg.sv
package led_ramp_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_BOOST  = 2'b10,
        MODE_EXTSUP = 2'b11
    } led_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_RISE,
        ST_FALL,
        ST_PARK
    } ramp_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       slow;
        logic       fs2x;
        logic [2:0] grad;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{mode: 2'b00, slow: 1'b0, fs2x: 1'b1, grad: 3'b111};

endpackage

// File: rtl/led_step_timer.sv
module led_step_timer #(
    parameter int STEP_UNIT = 16,
    parameter int GRAD_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              restart,
    input  logic              run,
    input  logic [GRAD_W-1:0] grad,
    output logic              expire
);
    localparam int N_ENT     = 1 << GRAD_W;
    localparam int MAX_TICKS = STEP_UNIT << (N_ENT - 2);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] lim_tab [N_ENT];
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    for (genvar g = 0; g < N_ENT; g++) begin : g_lim
        if (g == 0) begin : g_fast
            assign lim_tab[g] = CNT_W'(1);
        end else begin : g_bin
            assign lim_tab[g] = CNT_W'(STEP_UNIT << (g - 1));
        end
    end

    assign last   = (cnt_q == lim_tab[grad] - CNT_W'(1));
    assign expire = run && !restart && base_tick && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (base_tick) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/led_mode_decode.sv
module led_mode_decode
    import led_ramp_pkg::*;
(
    input  logic [1:0] mode,
    output logic       drive_ch1,
    output logic       drive_ch2,
    output logic       boost_mode,
    output logic       boost_power
);
    always_comb begin
        drive_ch1   = 1'b0;
        drive_ch2   = 1'b0;
        boost_mode  = 1'b0;
        boost_power = 1'b1;
        unique case (mode)
            MODE_DUAL: begin
                drive_ch1 = 1'b1;
                drive_ch2 = 1'b1;
            end
            MODE_SINGLE: begin
                drive_ch1 = 1'b1;
            end
            MODE_BOOST: begin
                boost_mode = 1'b1;
            end
            default: begin
                drive_ch1   = 1'b1;
                drive_ch2   = 1'b1;
                boost_power = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/led_ramp_ctrl.sv
module led_ramp_ctrl
    import led_ramp_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int STEP_UNIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_target,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              base_tick,
    output logic [7:0]        ctrl_rdata,
    output logic [CODE_W-1:0] led_code,
    output logic              fs_double,
    output logic              slow_edge,
    output logic              drive_ch1,
    output logic              drive_ch2,
    output logic              boost_mode,
    output logic              boost_power,
    output logic              led_en,
    output logic              ramp_done
);
    ctrl_t             ctrl_q, ctrl_d;
    logic [CODE_W-1:0] target_q, target_d;
    logic [CODE_W-1:0] present_q, present_d;
    ramp_state_e       state_q, state_d;
    logic              expire;
    logic              restart;
    logic              run;

    assign restart = wr_ctrl || wr_target;
    assign run     = (state_q == ST_RISE) || (state_q == ST_FALL);

    led_step_timer #(.STEP_UNIT(STEP_UNIT), .GRAD_W(3)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .restart  (restart),
        .run      (run),
        .grad     (ctrl_q.grad),
        .expire   (expire)
    );

    led_mode_decode decode_i (
        .mode       (ctrl_q.mode),
        .drive_ch1  (drive_ch1),
        .drive_ch2  (drive_ch2),
        .boost_mode (boost_mode),
        .boost_power(boost_power)
    );

    // next register values and the state they imply
    always_comb begin
        ctrl_d    = wr_ctrl   ? ctrl_t'(wr_data[6:0]) : ctrl_q;
        target_d  = wr_target ? wr_data : target_q;
        present_d = present_q;
        if (expire) begin
            unique case (state_q)
                ST_RISE: present_d = present_q + CODE_W'(1);
                ST_FALL: present_d = present_q - CODE_W'(1);
                default: present_d = present_q;
            endcase
        end
        if (ctrl_d.mode == MODE_BOOST) begin
            state_d = ST_PARK;
        end else if (present_d == target_d) begin
            state_d = ST_HOLD;
        end else if (present_d < target_d) begin
            state_d = ST_RISE;
        end else begin
            state_d = ST_FALL;
        end
    end

    // state and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= CTRL_RESET;
            target_q  <= '0;
            present_q <= '0;
            state_q   <= ST_HOLD;
        end else begin
            ctrl_q    <= ctrl_d;
            target_q  <= target_d;
            present_q <= present_d;
            state_q   <= state_d;
        end
    end

    // outputs
    always_comb begin
        ctrl_rdata = {1'b0, ctrl_q};
        fs_double  = ctrl_q.fs2x;
        slow_edge  = ctrl_q.slow;
        ramp_done  = (present_q == target_q);
        unique case (state_q)
            ST_PARK: begin
                led_code = '0;
                led_en   = 1'b0;
            end
            default: begin
                led_code = present_q;
                led_en   = (present_q != '0);
            end
        endcase
    end
endmodule

// File: rtl/led_ramp_chk.sv
module led_ramp_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctrl,
    input logic              wr_target,
    input logic [CODE_W-1:0] wr_data,
    input logic [7:0]        ctrl_rdata,
    input logic [CODE_W-1:0] led_code,
    input logic              led_en,
    input logic              ramp_done,
    input logic              boost_mode,
    input logic              drive_ch1,
    input logic              drive_ch2
);
    assert_wr_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl_rdata == {1'b0, $past(wr_data[6:0])});

    assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!boost_mode && $past(!boost_mode)) |->
            (led_code == $past(led_code) ||
             led_code == $past(led_code) + CODE_W'(1) ||
             led_code == $past(led_code) - CODE_W'(1)));

    assert_boost_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        boost_mode |-> (led_code == '0 && !led_en));

    assert_en_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        led_en |-> led_code != '0);

    assert_done_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && !wr_ctrl && !wr_target) |=> $stable(led_code));

    assert_boost_nodrive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        boost_mode |-> (!drive_ch1 && !drive_ch2));
endmodule

bind led_ramp_ctrl led_ramp_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_target (wr_target),
    .wr_data   (wr_data),
    .ctrl_rdata(ctrl_rdata),
    .led_code  (led_code),
    .led_en    (led_en),
    .ramp_done (ramp_done),
    .boost_mode(boost_mode),
    .drive_ch1 (drive_ch1),
    .drive_ch2 (drive_ch2)
);

// File: tb/led_ramp_ctrl_tb_top.sv
module led_ramp_ctrl_tb_top;
    localparam int UNIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic       wr_target = 1'b0;
    logic [7:0] wr_data = '0;
    logic       base_tick = 1'b1;
    logic [7:0] ctrl_rdata;
    logic [7:0] led_code;
    logic       fs_double, slow_edge, drive_ch1, drive_ch2;
    logic       boost_mode, boost_power, led_en, ramp_done;

    int n_checks = 0;
    int n_errors = 0;
    int cur = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    led_ramp_ctrl #(.CODE_W(8), .STEP_UNIT(UNIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_target(wr_target),
        .wr_data(wr_data), .base_tick(base_tick), .ctrl_rdata(ctrl_rdata),
        .led_code(led_code), .fs_double(fs_double), .slow_edge(slow_edge),
        .drive_ch1(drive_ch1), .drive_ch2(drive_ch2), .boost_mode(boost_mode),
        .boost_power(boost_power), .led_en(led_en), .ramp_done(ramp_done)
    );

    function automatic int ticks_for(input int code);
        return (code == 0) ? 1 : (UNIT << (code - 1));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller sits just after a falling edge
    task automatic wr(input bit is_ctrl, input logic [7:0] d);
        wr_ctrl   = is_ctrl;
        wr_target = !is_ctrl;
        wr_data   = d;
        @(posedge clk);
        @(negedge clk);
        wr_ctrl   = 1'b0;
        wr_target = 1'b0;
    endtask

    // after a target write with base_tick high: check each step's timing
    task automatic ramp_check(input int start, input int tgt, input int lim, input string req);
        int v = start;
        int bad = 0;
        int badv = 0;
        int bade = 0;
        while (v != tgt) begin
            if (lim > 1) begin
                repeat (lim - 1) @(negedge clk);
                if (int'(led_code) != v && bad == 0) begin bad = 1; badv = led_code; bade = v; end
            end
            @(negedge clk);
            v = (tgt > v) ? v + 1 : v - 1;
            if (int'(led_code) != v && bad == 0) begin bad = 1; badv = led_code; bade = v; end
        end
        check(req, (bad == 0) ? 1 : badv + 1000, (bad == 0) ? 1 : bade + 1000);
        repeat (lim + 1) @(negedge clk);
        check({req, " no overshoot"}, led_code, tgt);
        check("R9 done at target", ramp_done, 1);
        check("R8 enable", led_en, (tgt != 0) ? 1 : 0);
        cur = tgt;
    endtask

    function automatic logic [7:0] ctrl_byte(input int mode, input int slow, input int fs, input int grad);
        return {1'b0, 2'(mode), 1'(slow), 1'(fs), 3'(grad)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int v;
        int tgt;
        int g;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctrl readback", ctrl_rdata, 8'h0F);
        check("R1 led_code", led_code, 0);
        check("R1 led_en", led_en, 0);
        check("R1 ramp_done", ramp_done, 1);
        check("R2 fs_double reset", fs_double, 1);

        // R2 bit 7 ignored, fields
        wr(1'b1, 8'hFF);
        check("R2 bit7 reads 0", ctrl_rdata, 8'h7F);
        check("R2 slow_edge", slow_edge, 1);
        check("R3 mode 11 boost_power", boost_power, 0);
        check("R3 mode 11 channels", {drive_ch1, drive_ch2}, 2'b11);
        wr(1'b1, ctrl_byte(1, 0, 0, 0));
        check("R10 write takes effect", ctrl_rdata, 8'h20);
        check("R2 fs_double clear", fs_double, 0);
        check("R3 mode 01 channels", {drive_ch1, drive_ch2, boost_power}, 3'b101);
        wr(1'b1, ctrl_byte(2, 0, 1, 0));
        check("R3 mode 10 decode", {drive_ch1, drive_ch2, boost_mode, boost_power}, 4'b0011);
        wr(1'b1, ctrl_byte(0, 0, 1, 0));
        check("R3 mode 00 decode", {drive_ch1, drive_ch2, boost_mode, boost_power}, 4'b1101);

        // R4/R5 directed: full-scale ramp up at fastest code, down at code 1
        wr(1'b0, 8'hFF);
        check("R9 not done mid ramp", ramp_done, 0);
        ramp_check(0, 255, 1, "R4 R5 code000 up");
        wr(1'b1, ctrl_byte(0, 0, 1, 1));
        wr(1'b0, 8'h00);
        ramp_check(255, 0, ticks_for(1), "R4 R5 code001 down");
        check("R8 zero code disabled", led_en, 0);

        // R4 slowest entry: one step
        wr(1'b1, ctrl_byte(0, 0, 1, 7));
        wr(1'b0, 8'h01);
        ramp_check(0, 1, ticks_for(7), "R4 code111 step");

        // R6 restart on target rewrite mid-interval
        wr(1'b1, ctrl_byte(0, 0, 1, 3));
        wr(1'b0, 8'h03);
        repeat (10) @(negedge clk);
        check("R6 no step before interval", led_code, 1);
        wr(1'b0, 8'h03);
        ramp_check(1, 3, ticks_for(3), "R6 restart after rewrite");

        // R10 gated base tick
        wr(1'b1, ctrl_byte(0, 0, 1, 1));
        base_tick = 1'b0;
        wr(1'b0, 8'h04);
        repeat (40) @(negedge clk);
        check("R10 no tick no step", led_code, 3);
        for (int i = 0; i < UNIT - 1; i++) begin
            base_tick = 1'b1; @(negedge clk); base_tick = 1'b0; repeat (2) @(negedge clk);
        end
        check("R10 short of interval", led_code, 3);
        base_tick = 1'b1; @(negedge clk); base_tick = 1'b0; @(negedge clk);
        check("R10 R4 step after ticks", led_code, 4);
        base_tick = 1'b1;
        cur = 4;

        // R7 boost freeze mid ramp
        wr(1'b0, 8'd200);
        repeat (9 * ticks_for(1) + 2) @(negedge clk);
        v = led_code;
        wr(1'b1, ctrl_byte(2, 0, 1, 1));
        check("R7 boost code zero", led_code, 0);
        check("R7 R8 boost disabled", led_en, 0);
        repeat (50) @(negedge clk);
        check("R7 still zero", led_code, 0);
        wr(1'b1, ctrl_byte(0, 0, 1, 1));
        check("R7 held code restored", led_code, v);
        ramp_check(v, 200, ticks_for(1), "R7 resume ramp");

        // constrained random trials
        for (int t = 0; t < 12; t++) begin
            g   = $urandom_range(0, 3);
            tgt = $urandom_range(0, 255);
            v   = $urandom_range(0, 1);
            wr(1'b1, ctrl_byte(v * 3, t % 2, (t / 2) % 2, g));
            check("R2 random readback", ctrl_rdata, ctrl_byte(v * 3, t % 2, (t / 2) % 2, g));
            check("R2 random flags", {slow_edge, fs_double}, {1'(t % 2), 1'((t / 2) % 2)});
            wr(1'b0, 8'(tgt));
            ramp_check(cur, tgt, ticks_for(g), "R5 random ramp");
        end

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule